// File: doc/BRIEF.md
# Periodic Tick Housekeeping Unit

This block is driven by a periodic timer tick pulse. Each accepted tick starts a fixed four-step sequence, one step per clock cycle. First, a free-running tick counter advances; when it passes its maximum it wraps to zero and raises a sticky rollover flag. Second, a one-byte motor-off countdown steps down toward zero and switches off the drive motor enables once it gets there. Third, a one-cycle user-tick event is emitted so that other logic can schedule its own timed work. Last, a one-cycle end-of-interrupt pulse tells the interrupt controller that further device requests may be raised.

A small register port gives access to the block. Software can read the count. It can read the status word, which returns the rollover flag and a saturating count of ticks that arrived while a sequence was still running; that read also clears the flag. It can write the motor register, which reloads the countdown and sets the motor enables. Producing the tick and converting the count to a time of day are handled elsewhere.

Top module: `tick_keeper`

## Requirements
- R1: Each accepted tick adds exactly one to the tick count, which reads at register address 0; the count does not change at any other time.
- R2: A tick that finds the count at its maximum value (all ones over CNT_W bits) sets the count to zero and sets the rollover flag, which is bit 0 of the status word at address 1.
- R3: The rollover flag stays set until a read of address 1. That read returns the flag as set and clears it at the same clock edge.
- R4: The motor step of each tick lowers the motor-wait countdown by one. At zero the countdown holds and never wraps. It reads as bits [WAIT_W-1:0] of address 2.
- R5: When the motor step leaves the countdown at zero, all motor enable outputs turn off.
- R6: If a tick is sampled in idle at edge E, the count changes at E+1, the countdown changes at E+2, and user_tick_o is high for exactly the one cycle that follows E+2.
- R7: eoi_o is high for exactly one cycle, the cycle right after the user-tick pulse. The unit is idle again after that cycle.
- R8: A write to address 2 loads the countdown from wdata[WAIT_W-1:0] and the motor enables from wdata[WAIT_W+NUM_MOTORS-1:WAIT_W]. This is the only way an enable can turn on. If the write meets a motor step at the same edge, the write wins and that step's decrement is skipped.
- R9: A tick that arrives while a sequence is running is ignored and does not change the count. Each such tick adds one to a missed-tick counter in status bits [8+MISS_W-1:8], which saturates at all ones.
- R10: After reset the count, the rollover flag, the countdown, the enables, the missed-tick counter, user_tick_o and eoi_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Periodic tick pulse |
| reg_en_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address (0 count, 1 status, 2 motor) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the same cycle as the strobe |
| motor_en_o | output | NUM_MOTORS | Drive motor enables |
| user_tick_o | output | 1 | One-cycle user-tick event |
| eoi_o | output | 1 | One-cycle end-of-interrupt pulse |

## Verification
A wrong sequencer state shows at the ports within one cycle. The user-tick or end-of-interrupt pulse then moves, doubles or disappears compared with the tick that started it. A count or rollover error becomes visible at the first register read after that tick, and the bench reads the count after every tick. A countdown error stays hidden until the countdown register is read or an enable is due to turn off. For that reason the bench reads the motor register after every tick, and it reads the status word at random points to expose the missed-tick counter and the flag.

// File: rtl/tick_keeper_pkg.sv
package tick_keeper_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_MOTOR = 3'd2,
    ST_USER  = 3'd3,
    ST_EOI   = 3'd4
  } seq_state_e;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_MOTOR  = 2'd2;
  localparam int unsigned STATUS_MISS_LSB = 8;
endpackage

// File: rtl/tk_sequencer.sv
module tk_sequencer
  import tick_keeper_pkg::*;
#(
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  output logic              cnt_step_o,
  output logic              mot_step_o,
  output logic              user_tick_o,
  output logic              eoi_o,
  output logic [MISS_W-1:0] missed_o
);
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};
  localparam logic [MISS_W-1:0] MISS_ONE = MISS_W'(1);

  seq_state_e        state_q, state_d;
  logic [MISS_W-1:0] missed_q, missed_d;
  logic              missed_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (tick_i) state_d = ST_COUNT;
      ST_COUNT: state_d = ST_MOTOR;
      ST_MOTOR: state_d = ST_USER;
      ST_USER:  state_d = ST_EOI;
      ST_EOI:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    missed_en = tick_i && (state_q != ST_IDLE) && (missed_q != MISS_MAX);
    missed_d  = missed_q + MISS_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      missed_q <= '0;
    end else begin
      state_q <= state_d;
      if (missed_en) missed_q <= missed_d;
    end
  end

  assign cnt_step_o  = (state_q == ST_COUNT);
  assign mot_step_o  = (state_q == ST_MOTOR);
  assign user_tick_o = (state_q == ST_USER);
  assign eoi_o       = (state_q == ST_EOI);
  assign missed_o    = missed_q;

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_step_o, mot_step_o, user_tick_o, eoi_o}));
  assert_cnt_then_mot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step_o |=> mot_step_o);
  assert_mot_then_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mot_step_o |=> user_tick_o);
  assert_user_then_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    user_tick_o |=> (eoi_o && !user_tick_o));
  assert_eoi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_o |=> !eoi_o);
  assert_busy_tick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (state_q != ST_IDLE)) |=> !cnt_step_o);
  assert_miss_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_q == MISS_MAX) |=> (missed_q == MISS_MAX));
endmodule

// File: rtl/tk_tick_counter.sv
module tk_tick_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             clr_flag_i,
  output logic [CNT_W-1:0] count_o,
  output logic             roll_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             roll_q, roll_d;
  logic             at_max;

  always_comb begin
    at_max  = (count_q == CNT_MAX);
    count_d = at_max ? '0 : (count_q + CNT_ONE);
    roll_d  = roll_q;
    if (clr_flag_i)        roll_d = 1'b0;
    if (step_i && at_max)  roll_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      roll_q  <= 1'b0;
    end else begin
      if (step_i) count_q <= count_d;
      roll_q <= roll_d;
    end
  end

  assign count_o = count_q;
  assign roll_o  = roll_q;

  assert_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (count_q != CNT_MAX)) |=> (count_q == $past(count_q) + CNT_ONE));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(count_q));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (count_q == CNT_MAX)) |=> ((count_q == '0) && roll_q));
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_q && !clr_flag_i) |=> roll_q);
endmodule

// File: rtl/tk_motor_timer.sv
module tk_motor_timer #(
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned NUM_MOTORS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_i,
  input  logic                  load_i,
  input  logic [WAIT_W-1:0]     load_wait_i,
  input  logic [NUM_MOTORS-1:0] load_en_i,
  output logic [WAIT_W-1:0]     wait_o,
  output logic [NUM_MOTORS-1:0] motor_en_o
);
  localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

  logic [WAIT_W-1:0]     wait_q, wait_d;
  logic [NUM_MOTORS-1:0] en_q, en_d;
  logic                  upd_en;

  always_comb begin
    wait_d = wait_q;
    en_d   = en_q;
    if (load_i) begin
      wait_d = load_wait_i;
      en_d   = load_en_i;
    end else if (step_i) begin
      if (wait_q != '0) wait_d = wait_q - WAIT_ONE;
      if (wait_q <= WAIT_ONE) en_d = '0;
    end
    upd_en = load_i || step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      en_q   <= '0;
    end else if (upd_en) begin
      wait_q <= wait_d;
      en_q   <= en_d;
    end
  end

  assign wait_o     = wait_q;
  assign motor_en_o = en_q;

  assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (wait_q == '0)) |=> (wait_q == '0));
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (wait_q != '0)) |=> (wait_q == $past(wait_q) - WAIT_ONE));
  assert_off_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (wait_q <= WAIT_ONE)) |=> (en_q == '0));
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ((wait_q == $past(load_wait_i)) && (en_q == $past(load_en_i))));
  assert_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/tick_keeper.sv
module tick_keeper
  import tick_keeper_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned NUM_MOTORS = 4,
  parameter int unsigned MISS_W     = 8,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  reg_en_i,
  input  logic                  reg_wr_i,
  input  logic [1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_MOTORS-1:0] motor_en_o,
  output logic                  user_tick_o,
  output logic                  eoi_o
);
  localparam int unsigned EN_LSB = WAIT_W;

  logic                  cnt_step, mot_step;
  logic [MISS_W-1:0]     missed;
  logic [CNT_W-1:0]      count;
  logic                  roll;
  logic [WAIT_W-1:0]     wait_val;
  logic                  rd_status, wr_motor;

  always_comb begin
    rd_status = reg_en_i && !reg_wr_i && (reg_addr_i == ADDR_STATUS);
    wr_motor  = reg_en_i &&  reg_wr_i && (reg_addr_i == ADDR_MOTOR);
  end

  tk_sequencer #(.MISS_W(MISS_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .cnt_step_o  (cnt_step),
    .mot_step_o  (mot_step),
    .user_tick_o (user_tick_o),
    .eoi_o       (eoi_o),
    .missed_o    (missed)
  );

  tk_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (cnt_step),
    .clr_flag_i (rd_status),
    .count_o    (count),
    .roll_o     (roll)
  );

  tk_motor_timer #(.WAIT_W(WAIT_W), .NUM_MOTORS(NUM_MOTORS)) u_mot (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (mot_step),
    .load_i      (wr_motor),
    .load_wait_i (reg_wdata_i[WAIT_W-1:0]),
    .load_en_i   (reg_wdata_i[EN_LSB +: NUM_MOTORS]),
    .wait_o      (wait_val),
    .motor_en_o  (motor_en_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_en_i && !reg_wr_i) begin
      unique case (reg_addr_i)
        ADDR_COUNT:  reg_rdata_o[CNT_W-1:0] = count;
        ADDR_STATUS: begin
          reg_rdata_o[0] = roll;
          reg_rdata_o[STATUS_MISS_LSB +: MISS_W] = missed;
        end
        ADDR_MOTOR: begin
          reg_rdata_o[WAIT_W-1:0] = wait_val;
          reg_rdata_o[EN_LSB +: NUM_MOTORS] = motor_en_o;
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assert_status_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !cnt_step) |=> !roll);
  assert_user_not_with_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(user_tick_o && eoi_o));
endmodule

// File: tb/tick_keeper_tb.sv
module tick_keeper_tb;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              tick_i;
  logic              reg_en_i;
  logic              reg_wr_i;
  logic [1:0]        reg_addr_i;
  logic [DATA_W-1:0] reg_wdata_i;
  logic [DATA_W-1:0] reg_rdata_o;
  logic [3:0]        motor_en_o;
  logic              user_tick_o;
  logic              eoi_o;

  int n_checks;
  int n_errors;
  bit finished;

  int       m_count;
  bit       m_roll;
  int       m_wait;
  bit [3:0] m_en;
  int       m_miss;

  tick_keeper #(.CNT_W(CNT_W), .WAIT_W(8), .NUM_MOTORS(4), .MISS_W(8), .DATA_W(DATA_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .reg_en_i    (reg_en_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .motor_en_o  (motor_en_o),
    .user_tick_o (user_tick_o),
    .eoi_o       (eoi_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int next_count(int c);
    return (c == 255) ? 0 : c + 1;
  endfunction

  function automatic int next_wait(int w);
    return (w == 0) ? 0 : w - 1;
  endfunction

  function automatic bit [31:0] motor_word(int w, bit [3:0] en);
    return {20'd0, en, w[7:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] addr, output logic [31:0] data);
    reg_en_i   = 1'b1;
    reg_wr_i   = 1'b0;
    reg_addr_i = addr;
    #1 data = reg_rdata_o;
    @(negedge clk);
    reg_en_i = 1'b0;
    if (addr == 2'd1) m_roll = 1'b0;
  endtask

  task automatic wr_motor(input int w, input bit [3:0] en);
    reg_en_i    = 1'b1;
    reg_wr_i    = 1'b1;
    reg_addr_i  = 2'd2;
    reg_wdata_i = motor_word(w, en);
    @(negedge clk);
    reg_en_i = 1'b0;
    reg_wr_i = 1'b0;
    m_wait   = w;
    m_en     = en;
  endtask

  task automatic check_status(string tag);
    logic [31:0] d;
    logic [31:0] exp;
    exp = {16'd0, m_miss[7:0], 7'd0, m_roll};
    rd(2'd1, d);
    check(tag, d, exp);
  endtask

  // one full tick sequence; extra = second tick while busy, mid = motor write on the motor-step edge
  task automatic do_tick(input bit extra, input bit mid, input int mw, input bit [3:0] men);
    logic [31:0] d;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check("R6 user_tick low after sample", {30'd0, user_tick_o, eoi_o}, 32'd0);
    @(negedge clk);
    if (m_count == 255) m_roll = 1'b1;
    m_count = next_count(m_count);
    if (extra) tick_i = 1'b1;
    if (mid) begin
      reg_en_i    = 1'b1;
      reg_wr_i    = 1'b1;
      reg_addr_i  = 2'd2;
      reg_wdata_i = motor_word(mw, men);
    end
    @(negedge clk);
    tick_i   = 1'b0;
    reg_en_i = 1'b0;
    reg_wr_i = 1'b0;
    if (extra && m_miss < 255) m_miss++;
    if (mid) begin
      m_wait = mw;
      m_en   = men;
    end else begin
      m_wait = next_wait(m_wait);
      if (m_wait == 0) m_en = 4'd0;
    end
    check("R6 user_tick pulse", {30'd0, user_tick_o, eoi_o}, 32'd2);
    @(negedge clk);
    check("R7 eoi pulse", {30'd0, user_tick_o, eoi_o}, 32'd1);
    @(negedge clk);
    check("R7 eoi single cycle", {30'd0, user_tick_o, eoi_o}, 32'd0);
    rd(2'd0, d);
    check("R1 R9 count after tick", d, m_count);
    rd(2'd2, d);
    check("R4 R8 motor register", d, motor_word(m_wait, m_en));
    check("R5 motor enables", {28'd0, motor_en_o}, {28'd0, m_en});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    n_checks = 0; n_errors = 0; finished = 1'b0;
    m_count = 0; m_roll = 1'b0; m_wait = 0; m_en = 4'd0; m_miss = 0;
    tick_i = 1'b0; reg_en_i = 1'b0; reg_wr_i = 1'b0;
    reg_addr_i = 2'd0; reg_wdata_i = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 user_tick/eoi", {30'd0, user_tick_o, eoi_o}, 32'd0);
    check("R10 motor enables", {28'd0, motor_en_o}, 32'd0);
    rd(2'd0, d); check("R10 count", d, 32'd0);
    rd(2'd2, d); check("R10 motor register", d, 32'd0);
    check_status("R10 status");

    // R8 load, R4 countdown, R5 enables off at zero
    wr_motor(3, 4'b0101);
    check("R8 enables on after write", {28'd0, motor_en_o}, 32'h5);
    do_tick(1'b0, 1'b0, 0, 4'd0);
    do_tick(1'b0, 1'b0, 0, 4'd0);
    check("R5 enables still on at 1", {28'd0, motor_en_o}, 32'h5);
    do_tick(1'b0, 1'b0, 0, 4'd0);
    check("R5 enables off at 0", {28'd0, motor_en_o}, 32'h0);
    do_tick(1'b0, 1'b0, 0, 4'd0);
    rd(2'd2, d); check("R4 holds at zero", d, 32'd0);

    // R8 write on the motor-step edge wins
    wr_motor(5, 4'hF);
    do_tick(1'b0, 1'b1, 9, 4'h3);
    rd(2'd2, d); check("R8 write beats decrement", d, motor_word(9, 4'h3));

    // R9 busy tick ignored and counted
    do_tick(1'b1, 1'b0, 0, 4'd0);
    check_status("R9 missed count one");

    // R2 rollover at maximum, R3 sticky until read
    while (m_count != 255) do_tick(1'b1, 1'b0, 0, 4'd0);
    check_status("R2 no flag before wrap");
    do_tick(1'b0, 1'b0, 0, 4'd0);
    rd(2'd0, d); check("R2 count wrapped to zero", d, 32'd0);
    do_tick(1'b0, 1'b0, 0, 4'd0);
    rd(2'd1, d); check("R3 flag held until read", d[0], 1'b1);
    check_status("R3 flag cleared by read");

    // R9 saturation
    repeat (12) do_tick(1'b1, 1'b0, 0, 4'd0);
    check_status("R9 missed saturates");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel;
      sel = $urandom % 5;
      case (sel)
        0: do_tick(1'b0, 1'b0, 0, 4'd0);
        1: do_tick(1'b1, 1'b0, 0, 4'd0);
        2: do_tick(1'b0, 1'b1, $urandom % 6, 4'($urandom));
        3: begin
          wr_motor($urandom % 6, 4'($urandom));
          do_tick(1'b0, 1'b0, 0, 4'd0);
        end
        default: check_status("R3 R9 random status");
      endcase
      if (($urandom % 4) == 0) @(negedge clk);
    end

    finish_run();
  end
endmodule